// File: doc/BRIEF.md
# Receive-Enable Training Sequencer

This block trains the receive-enable delay of one memory channel. The channel has four byte-lane groups. Each group is trained in turn. The sequencer keeps a working delay made of four fields: coarse, phase, tap and fine. It moves that delay in fixed step sizes and hands every new setting to an external delay stepper. After the stepper acknowledges a setting, it asks a sampler for the strobe levels seen on the two lanes that belong to the group. The search runs in a fixed order. First it walks forward until the strobe is low. It then hunts the low-to-high edge: a coarse pass in quarter steps, then a fine pass in single fine steps. Next it steps back one whole coarse unit at a time to find the preamble low. It hunts the edge a second time and finishes with a half-period backstep.

When every group has a result, the sequencer finds the smallest coarse value among the groups. It reports that value as the shared coarse delay, and each group gets a 2-bit pre-delay equal to its own coarse value minus the shared one. It then programs the factored settings through the stepper handshake, group by group, and raises `done`. A raw-card input selects the alternate lane wiring. In that wiring every group reads a single lane twice and gets one extra tap at the end. Any error stops the run with `done` and `err` high and a cause code.

Top module: `rec_train_seq`

## Requirements
- R1: After reset, `done`, `err`, `apply_req` and `smp_req` are low, and while `done` is high neither request is raised.
- R2: Each `smp_req` rises only in the cycle after an `apply_req`/`apply_done` handshake completes, the two requests are never high together, and each sample follows its own completed setting.
- R3: With `card_alt` low, group g samples lane 2g on `smp_lane0` and lane 2g+1 on `smp_lane1`; `smp_lvl[0]` is the level of `smp_lane0` and `smp_lvl[1]` that of `smp_lane1`.
- R4: With `card_alt` high, groups 0, 1, 2 and 3 sample lane 0, 3, 6 and 5 respectively on both `smp_lane0` and `smp_lane1`.
- R5: A group starts at coarse `C_INIT` (phase, tap and fine zero). It moves forward one quarter step (T_BOUND/2 taps plus, for odd T_BOUND, P_BOUND/2 fine) while either level is high.
- R6: The edge hunt adds 2 taps, quarter-steps forward until either level is high, steps one quarter back, then adds one fine unit at a time until both levels are high. It therefore ends on the later of the two lane edges.
- R7: After the first edge hunt, one quarter step is taken and then one coarse unit is subtracted while either level is high; the edge hunt then runs again.
- R8: A group's result is its second edge position minus half a coarse unit (phase minus 2), plus one tap when `card_alt` is high.
- R9: The shared coarse `res_coarse` is the minimum group coarse value and each `res_pre` field is the group's coarse value minus it. A difference above 3 ends the run with `err_code` 3.
- R10: Fine wraps at P_BOUND into tap, tap wraps at T_BOUND into phase (units of 2), and phase wraps at 4 into coarse. A coarse value below 0 or at least C_LIMIT ends the run with `err_code` 1.
- R11: More than MAX_ITER consecutive steps within one search phase end the run with `err_code` 2.
- R12: `done` and all result outputs hold until the next `start`, and a `start` while done clears `done` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle or done) |
| card_alt | input | 1 | Alternate raw-card lane wiring, captured at start |
| done | output | 1 | Run finished (successfully or with error) |
| err | output | 1 | Run ended in error |
| err_code | output | 2 | 0 none, 1 coarse range, 2 loop watchdog, 3 pre-delay range |
| apply_req | output | 1 | Request to program a delay setting |
| apply_grp | output | GW | Group the setting belongs to |
| apply_coarse | output | CW | Coarse field of the setting |
| apply_pre | output | 2 | Pre-delay field of the setting |
| apply_ph | output | 2 | Phase field (0 or 2) |
| apply_tap | output | TW | Tap field |
| apply_fine | output | PW | Fine field |
| apply_done | input | 1 | Stepper acknowledges the setting |
| smp_req | output | 1 | Request a test read and level sample |
| smp_lane0 | output | LW | First lane to sample |
| smp_lane1 | output | LW | Second lane to sample |
| smp_ack | input | 1 | Sample is valid |
| smp_lvl | input | 2 | Sampled strobe levels of lane0 (bit 0) and lane1 (bit 1) |
| res_coarse | output | CW | Shared coarse delay |
| res_pre | output | 2*GROUPS | Per-group pre-delay, group g at bits 2g+1:2g |
| res_ph | output | 2*GROUPS | Per-group phase |
| res_tap | output | TW*GROUPS | Per-group tap |
| res_fine | output | PW*GROUPS | Per-group fine |

## Verification
The bench builds the block with T_BOUND = 9 and P_BOUND = 8. This odd tap bound makes each quarter step carry four fine units, so quarter, quarter-back and fine steps all pass carries through the fine, tap, phase and coarse fields. C_INIT = 2 lets one scenario start inside the low window and another start before it. Coarse underflow is reachable with a narrow window. MAX_ITER = 100 is above the longest fine hunt of a legal edge spread, yet a stuck lane still trips the watchdog well before coarse overflow.

// File: rtl/rec_pkg.sv
package rec_pkg;

  localparam int PHASE_WRAP = 4;
  localparam int PHASE_UNIT = 2;

  typedef enum logic [2:0] {
    OP_QF,
    OP_QB,
    OP_FINE,
    OP_TAP2,
    OP_CBACK,
    OP_HALFB,
    OP_HALFB_TAP1
  } step_op_t;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_HIGH,
    PH_FINE,
    PH_PRE
  } hunt_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_APPLY,
    S_SAMPLE,
    S_DECIDE,
    S_FACTOR,
    S_FGAP,
    S_DONE
  } seq_state_t;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_RANGE = 2'd1;
  localparam logic [1:0] ERR_WDOG  = 2'd2;
  localparam logic [1:0] ERR_PRE   = 2'd3;

endpackage

// File: rtl/rec_step_norm.sv
module rec_step_norm #(
  parameter int T_BOUND = 12,
  parameter int P_BOUND = 1,
  parameter int C_LIMIT = 16,
  parameter int CW      = 4,
  parameter int TW      = 4,
  parameter int PW      = 1
) (
  input  rec_pkg::step_op_t op,
  input  logic [CW-1:0]     c_in,
  input  logic [1:0]        ph_in,
  input  logic [TW-1:0]     t_in,
  input  logic [PW-1:0]     p_in,
  output logic [CW-1:0]     c_out,
  output logic [1:0]        ph_out,
  output logic [TW-1:0]     t_out,
  output logic [PW-1:0]     p_out,
  output logic              range_err
);
  import rec_pkg::*;

  localparam int QT = T_BOUND / 2;
  localparam int QP = (T_BOUND % 2) * (P_BOUND / 2);

  int dc, dph, dt, dp;
  int pv, tv, hv, cv;

  always_comb begin
    dc = 0; dph = 0; dt = 0; dp = 0;
    case (op)
      OP_QF:         begin dt = QT;  dp = QP;  end
      OP_QB:         begin dt = -QT; dp = -QP; end
      OP_FINE:       dp = 1;
      OP_TAP2:       dt = 2;
      OP_CBACK:      dc = -1;
      OP_HALFB:      dph = -PHASE_UNIT;
      OP_HALFB_TAP1: begin dph = -PHASE_UNIT; dt = 1; end
      default:       dc = 0;
    endcase

    // fine -> tap carry
    pv = int'(p_in) + dp;
    tv = int'(t_in) + dt;
    if (pv >= P_BOUND) begin
      pv = pv - P_BOUND;
      tv = tv + 1;
    end else if (pv < 0) begin
      pv = pv + P_BOUND;
      tv = tv - 1;
    end

    // tap -> phase carry
    hv = int'(ph_in) + dph;
    if (tv >= T_BOUND) begin
      tv = tv - T_BOUND;
      hv = hv + PHASE_UNIT;
    end else if (tv < 0) begin
      tv = tv + T_BOUND;
      hv = hv - PHASE_UNIT;
    end

    // phase -> coarse carry
    cv = int'(c_in) + dc;
    if (hv >= PHASE_WRAP) begin
      hv = hv - PHASE_WRAP;
      cv = cv + 1;
    end else if (hv < 0) begin
      hv = hv + PHASE_WRAP;
      cv = cv - 1;
    end

    range_err = (cv < 0) || (cv >= C_LIMIT);
    c_out  = CW'(cv);
    ph_out = 2'(hv);
    t_out  = TW'(tv);
    p_out  = PW'(pv);
  end

endmodule

// File: rtl/rec_lane_map.sv
module rec_lane_map #(
  parameter int GROUPS = 4,
  parameter int GW     = 2,
  parameter int LW     = 3
) (
  input  logic [GW-1:0] grp,
  input  logic          alt,
  output logic [LW-1:0] lane0,
  output logic [LW-1:0] lane1
);

  function automatic int alt_lane(input int g);
    case (g)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 5;
      default: return 2 * g;
    endcase
  endfunction

  always_comb begin
    if (alt) begin
      lane0 = LW'(alt_lane(int'(grp)));
      lane1 = LW'(alt_lane(int'(grp)));
    end else begin
      lane0 = LW'(2 * int'(grp));
      lane1 = LW'(2 * int'(grp) + 1);
    end
  end

endmodule

// File: rtl/rec_coarse_factor.sv
module rec_coarse_factor #(
  parameter int GROUPS = 4,
  parameter int CW     = 4
) (
  input  logic [GROUPS*CW-1:0] c_all,
  output logic [CW-1:0]        c_min,
  output logic [2*GROUPS-1:0]  pre_all,
  output logic                 pre_big
);

  logic [CW-1:0] diff [GROUPS];

  always_comb begin
    c_min = '1;
    for (int g = 0; g < GROUPS; g++) begin
      if (c_all[g*CW +: CW] < c_min) c_min = c_all[g*CW +: CW];
    end
  end

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_pre
      assign diff[g] = c_all[g*CW +: CW] - c_min;
      assign pre_all[2*g +: 2] = diff[g][1:0];
    end
  endgenerate

  always_comb begin
    pre_big = 1'b0;
    for (int g = 0; g < GROUPS; g++) begin
      if (int'(diff[g]) > 3) pre_big = 1'b1;
    end
  end

endmodule

// File: rtl/rec_train_seq.sv
module rec_train_seq #(
  parameter int T_BOUND  = 12,
  parameter int P_BOUND  = 1,
  parameter int C_LIMIT  = 16,
  parameter int C_INIT   = 5,
  parameter int GROUPS   = 4,
  parameter int MAX_ITER = 255,
  localparam int CW = $clog2(C_LIMIT),
  localparam int TW = $clog2(T_BOUND),
  localparam int PW = (P_BOUND > 1) ? $clog2(P_BOUND) : 1,
  localparam int GW = $clog2(GROUPS),
  localparam int LW = $clog2(2 * GROUPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   card_alt,
  output logic                   done,
  output logic                   err,
  output logic [1:0]             err_code,
  output logic                   apply_req,
  output logic [GW-1:0]          apply_grp,
  output logic [CW-1:0]          apply_coarse,
  output logic [1:0]             apply_pre,
  output logic [1:0]             apply_ph,
  output logic [TW-1:0]          apply_tap,
  output logic [PW-1:0]          apply_fine,
  input  logic                   apply_done,
  output logic                   smp_req,
  output logic [LW-1:0]          smp_lane0,
  output logic [LW-1:0]          smp_lane1,
  input  logic                   smp_ack,
  input  logic [1:0]             smp_lvl,
  output logic [CW-1:0]          res_coarse,
  output logic [2*GROUPS-1:0]    res_pre,
  output logic [2*GROUPS-1:0]    res_ph,
  output logic [TW*GROUPS-1:0]   res_tap,
  output logic [PW*GROUPS-1:0]   res_fine
);
  import rec_pkg::*;

  localparam int IW = $clog2(MAX_ITER + 1);
  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  seq_state_t     state;
  hunt_t          phase, nxt_phase;
  logic           alt_q, second, fin_q;
  logic [GW-1:0]  grp;
  logic [IW-1:0]  iter;
  logic [1:0]     lvl_q;

  logic [CW-1:0]  cur_c;
  logic [1:0]     cur_ph;
  logic [TW-1:0]  cur_t;
  logic [PW-1:0]  cur_p;

  logic [CW-1:0]  g_c   [GROUPS];
  logic [1:0]     g_pre [GROUPS];
  logic [1:0]     g_ph  [GROUPS];
  logic [TW-1:0]  g_t   [GROUPS];
  logic [PW-1:0]  g_p   [GROUPS];

  step_op_t       op_sel;
  logic           stay, finish;
  logic [CW-1:0]  n_c;
  logic [1:0]     n_ph;
  logic [TW-1:0]  n_t;
  logic [PW-1:0]  n_p;
  logic           n_bad;

  logic [LW-1:0]  map0, map1;
  logic [GROUPS*CW-1:0] c_pack;
  logic [CW-1:0]  f_min;
  logic [2*GROUPS-1:0] f_pre;
  logic           f_big;

  // ---------------- step decision ----------------
  always_comb begin
    op_sel    = OP_QF;
    nxt_phase = phase;
    stay      = 1'b1;
    finish    = 1'b0;
    case (phase)
      PH_LOW: begin
        if (|lvl_q) op_sel = OP_QF;
        else begin
          op_sel = OP_TAP2; nxt_phase = PH_HIGH; stay = 1'b0;
        end
      end
      PH_HIGH: begin
        if (!(|lvl_q)) op_sel = OP_QF;
        else begin
          op_sel = OP_QB; nxt_phase = PH_FINE; stay = 1'b0;
        end
      end
      PH_FINE: begin
        if (!(&lvl_q)) op_sel = OP_FINE;
        else if (!second) begin
          op_sel = OP_QF; nxt_phase = PH_PRE; stay = 1'b0;
        end else begin
          op_sel = alt_q ? OP_HALFB_TAP1 : OP_HALFB;
          stay   = 1'b0;
          finish = 1'b1;
        end
      end
      default: begin
        if (|lvl_q) op_sel = OP_CBACK;
        else begin
          op_sel = OP_TAP2; nxt_phase = PH_HIGH; stay = 1'b0;
        end
      end
    endcase
  end

  rec_step_norm #(
    .T_BOUND(T_BOUND), .P_BOUND(P_BOUND), .C_LIMIT(C_LIMIT),
    .CW(CW), .TW(TW), .PW(PW)
  ) u_norm (
    .op(op_sel), .c_in(cur_c), .ph_in(cur_ph), .t_in(cur_t), .p_in(cur_p),
    .c_out(n_c), .ph_out(n_ph), .t_out(n_t), .p_out(n_p), .range_err(n_bad)
  );

  rec_lane_map #(.GROUPS(GROUPS), .GW(GW), .LW(LW)) u_map (
    .grp(grp), .alt(alt_q), .lane0(map0), .lane1(map1)
  );

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_pack
      assign c_pack[g*CW +: CW]   = g_c[g];
      assign res_pre[2*g +: 2]    = g_pre[g];
      assign res_ph[2*g +: 2]     = g_ph[g];
      assign res_tap[g*TW +: TW]  = g_t[g];
      assign res_fine[g*PW +: PW] = g_p[g];
    end
  endgenerate

  rec_coarse_factor #(.GROUPS(GROUPS), .CW(CW)) u_factor (
    .c_all(c_pack), .c_min(f_min), .pre_all(f_pre), .pre_big(f_big)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      phase        <= PH_LOW;
      alt_q        <= 1'b0;
      second       <= 1'b0;
      fin_q        <= 1'b0;
      grp          <= '0;
      iter         <= '0;
      lvl_q        <= '0;
      cur_c        <= '0;
      cur_ph       <= '0;
      cur_t        <= '0;
      cur_p        <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      err_code     <= ERR_NONE;
      apply_req    <= 1'b0;
      apply_grp    <= '0;
      apply_coarse <= '0;
      apply_pre    <= '0;
      apply_ph     <= '0;
      apply_tap    <= '0;
      apply_fine   <= '0;
      smp_req      <= 1'b0;
      smp_lane0    <= '0;
      smp_lane1    <= '0;
      res_coarse   <= '0;
      for (int g = 0; g < GROUPS; g++) begin
        g_c[g] <= '0; g_pre[g] <= '0; g_ph[g] <= '0; g_t[g] <= '0; g_p[g] <= '0;
      end
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            alt_q        <= card_alt;
            grp          <= '0;
            phase        <= PH_LOW;
            second       <= 1'b0;
            fin_q        <= 1'b0;
            iter         <= '0;
            done         <= 1'b0;
            err          <= 1'b0;
            err_code     <= ERR_NONE;
            cur_c        <= CW'(C_INIT);
            cur_ph       <= '0;
            cur_t        <= '0;
            cur_p        <= '0;
            apply_req    <= 1'b1;
            apply_grp    <= '0;
            apply_coarse <= CW'(C_INIT);
            apply_pre    <= '0;
            apply_ph     <= '0;
            apply_tap    <= '0;
            apply_fine   <= '0;
            state        <= S_APPLY;
          end
        end

        S_APPLY: begin
          if (apply_done) begin
            apply_req <= 1'b0;
            if (fin_q) begin
              if (grp == LAST_GRP) begin
                done  <= 1'b1;
                state <= S_DONE;
              end else begin
                grp   <= grp + 1'b1;
                state <= S_FGAP;
              end
            end else begin
              smp_req   <= 1'b1;
              smp_lane0 <= map0;
              smp_lane1 <= map1;
              state     <= S_SAMPLE;
            end
          end
        end

        S_SAMPLE: begin
          if (smp_ack) begin
            smp_req <= 1'b0;
            lvl_q   <= smp_lvl;
            state   <= S_DECIDE;
          end
        end

        S_DECIDE: begin
          if (n_bad) begin
            err      <= 1'b1;
            err_code <= ERR_RANGE;
            done     <= 1'b1;
            state    <= S_DONE;
          end else if (stay && (iter == IW'(MAX_ITER))) begin
            err      <= 1'b1;
            err_code <= ERR_WDOG;
            done     <= 1'b1;
            state    <= S_DONE;
          end else if (finish) begin
            g_c[grp]  <= n_c;
            g_ph[grp] <= n_ph;
            g_t[grp]  <= n_t;
            g_p[grp]  <= n_p;
            if (grp == LAST_GRP) begin
              state <= S_FACTOR;
            end else begin
              grp          <= grp + 1'b1;
              phase        <= PH_LOW;
              second       <= 1'b0;
              iter         <= '0;
              cur_c        <= CW'(C_INIT);
              cur_ph       <= '0;
              cur_t        <= '0;
              cur_p        <= '0;
              apply_req    <= 1'b1;
              apply_grp    <= grp + 1'b1;
              apply_coarse <= CW'(C_INIT);
              apply_pre    <= '0;
              apply_ph     <= '0;
              apply_tap    <= '0;
              apply_fine   <= '0;
              state        <= S_APPLY;
            end
          end else begin
            cur_c        <= n_c;
            cur_ph       <= n_ph;
            cur_t        <= n_t;
            cur_p        <= n_p;
            phase        <= nxt_phase;
            iter         <= stay ? iter + 1'b1 : '0;
            if (phase == PH_FINE && nxt_phase == PH_PRE) second <= 1'b1;
            apply_req    <= 1'b1;
            apply_grp    <= grp;
            apply_coarse <= n_c;
            apply_pre    <= '0;
            apply_ph     <= n_ph;
            apply_tap    <= n_t;
            apply_fine   <= n_p;
            state        <= S_APPLY;
          end
        end

        S_FACTOR: begin
          if (f_big) begin
            err      <= 1'b1;
            err_code <= ERR_PRE;
            done     <= 1'b1;
            state    <= S_DONE;
          end else begin
            for (int g = 0; g < GROUPS; g++) g_pre[g] <= f_pre[2*g +: 2];
            res_coarse   <= f_min;
            fin_q        <= 1'b1;
            grp          <= '0;
            apply_req    <= 1'b1;
            apply_grp    <= '0;
            apply_coarse <= f_min;
            apply_pre    <= f_pre[1:0];
            apply_ph     <= g_ph[0];
            apply_tap    <= g_t[0];
            apply_fine   <= g_p[0];
            state        <= S_APPLY;
          end
        end

        S_FGAP: begin
          apply_req    <= 1'b1;
          apply_grp    <= grp;
          apply_coarse <= res_coarse;
          apply_pre    <= g_pre[grp];
          apply_ph     <= g_ph[grp];
          apply_tap    <= g_t[grp];
          apply_fine   <= g_p[grp];
          state        <= S_APPLY;
        end

        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_quiet_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!apply_req && !smp_req));

  assert_req_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(apply_req && smp_req));

  assert_sample_after_apply_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_req) |-> $past(apply_req && apply_done));

  assert_field_range_R10: assert property (@(posedge clk) disable iff (rst)
    apply_req |-> ((int'(apply_tap) < T_BOUND) && (int'(apply_fine) < P_BOUND) && !apply_ph[0]));

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(res_coarse) && $stable(res_pre) && $stable(err_code)));

endmodule

// File: tb/rec_train_seq_test.sv
module rec_train_seq_test;

  localparam int TB = 9;
  localparam int PB = 8;
  localparam int CL = 16;
  localparam int CI = 2;
  localparam int NG = 4;
  localparam int MI = 100;
  localparam int CW = $clog2(CL);
  localparam int TW = $clog2(TB);
  localparam int PW = $clog2(PB);
  localparam int GW = $clog2(NG);
  localparam int LW = $clog2(2 * NG);
  localparam int HALF_U   = TB * PB;
  localparam int COARSE_U = 2 * TB * PB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic card_alt = 1'b0;
  logic done, err;
  logic [1:0] err_code;
  logic apply_req;
  logic [GW-1:0] apply_grp;
  logic [CW-1:0] apply_coarse;
  logic [1:0] apply_pre, apply_ph;
  logic [TW-1:0] apply_tap;
  logic [PW-1:0] apply_fine;
  logic apply_done = 1'b0;
  logic smp_req;
  logic [LW-1:0] smp_lane0, smp_lane1;
  logic smp_ack = 1'b0;
  logic [1:0] smp_lvl = 2'b00;
  logic [CW-1:0] res_coarse;
  logic [2*NG-1:0] res_pre, res_ph;
  logic [TW*NG-1:0] res_tap;
  logic [PW*NG-1:0] res_fine;

  rec_train_seq #(
    .T_BOUND(TB), .P_BOUND(PB), .C_LIMIT(CL), .C_INIT(CI), .GROUPS(NG), .MAX_ITER(MI)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .card_alt(card_alt),
    .done(done), .err(err), .err_code(err_code),
    .apply_req(apply_req), .apply_grp(apply_grp), .apply_coarse(apply_coarse),
    .apply_pre(apply_pre), .apply_ph(apply_ph), .apply_tap(apply_tap),
    .apply_fine(apply_fine), .apply_done(apply_done),
    .smp_req(smp_req), .smp_lane0(smp_lane0), .smp_lane1(smp_lane1),
    .smp_ack(smp_ack), .smp_lvl(smp_lvl),
    .res_coarse(res_coarse), .res_pre(res_pre), .res_ph(res_ph),
    .res_tap(res_tap), .res_fine(res_fine)
  );

  initial forever #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // strobe model
  int  edge_e [8];
  bit  stuck_low [8];
  int  low_len = 260;
  bit  model_alt = 1'b0;
  int  cur_pos = 0;
  int  cur_grp = 0;
  bit  fresh = 1'b0;
  int  map_bad = 0;
  int  order_bad = 0;
  int  n_samples = 0;

  function automatic int lvl_of(input int lane, input int pos);
    if (stuck_low[lane]) return 0;
    return ((pos < edge_e[lane] - low_len) || (pos >= edge_e[lane])) ? 1 : 0;
  endfunction

  function automatic int exp_lane(input int g, input int which, input bit alt);
    if (alt) begin
      case (g)
        0: return 0;
        1: return 3;
        2: return 6;
        default: return 5;
      endcase
    end
    return 2 * g + which;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stepper responder
  initial forever begin
    @(negedge clk);
    if (apply_req && !apply_done) begin
      apply_done = 1'b1;
      cur_grp = int'(apply_grp);
      cur_pos = (int'(apply_coarse) + int'(apply_pre)) * COARSE_U
              + (int'(apply_ph) / 2) * HALF_U + int'(apply_tap) * PB + int'(apply_fine);
      fresh = 1'b1;
    end else begin
      apply_done = 1'b0;
    end
  end

  // sampler responder (R2, R3, R4 monitored here)
  initial forever begin
    @(negedge clk);
    if (smp_req && !smp_ack) begin
      n_samples++;
      if (apply_req || !fresh) order_bad++;
      fresh = 1'b0;
      if (int'(smp_lane0) != exp_lane(cur_grp, 0, model_alt) ||
          int'(smp_lane1) != exp_lane(cur_grp, 1, model_alt)) map_bad++;
      smp_lvl = {1'(lvl_of(int'(smp_lane1), cur_pos)), 1'(lvl_of(int'(smp_lane0), cur_pos))};
      smp_ack = 1'b1;
    end else begin
      smp_ack = 1'b0;
    end
  end

  task automatic set_model(input int e0, input int e1, input int e2, input int e3,
                           input int e4, input int e5, input int e6, input int e7,
                           input int len);
    edge_e[0] = e0; edge_e[1] = e1; edge_e[2] = e2; edge_e[3] = e3;
    edge_e[4] = e4; edge_e[5] = e5; edge_e[6] = e6; edge_e[7] = e7;
    for (int i = 0; i < 8; i++) stuck_low[i] = 1'b0;
    low_len = len;
  endtask

  task automatic run_cal(input bit alt);
    int n;
    model_alt = alt;
    map_bad = 0; order_bad = 0; n_samples = 0;
    @(negedge clk);
    card_alt = alt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R12 done cleared by start", int'(done), 0);
    n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R12 run completes", int'(done), 1);
  endtask

  task automatic check_results(input bit alt, input string tag);
    int ep [NG];
    int cg [NG];
    int mn, e, pos, pre, ph, tp, fn;
    mn = 1000;
    for (int g = 0; g < NG; g++) begin
      int a, b;
      a = edge_e[exp_lane(g, 0, alt)];
      b = edge_e[exp_lane(g, 1, alt)];
      e = (a > b) ? a : b;
      ep[g] = e - HALF_U + (alt ? PB : 0);
      cg[g] = ep[g] / COARSE_U;
      if (cg[g] < mn) mn = cg[g];
    end
    chk(err == 1'b0, {tag, " R10 no error"}, int'(err), 0);
    chk(int'(res_coarse) == mn, {tag, " R9 shared coarse"}, int'(res_coarse), mn);
    for (int g = 0; g < NG; g++) begin
      pre = int'(res_pre[2*g +: 2]);
      ph  = int'(res_ph[2*g +: 2]);
      tp  = int'(res_tap[g*TW +: TW]);
      fn  = int'(res_fine[g*PW +: PW]);
      chk(pre == cg[g] - mn, {tag, " R9 pre-delay"}, pre, cg[g] - mn);
      pos = (int'(res_coarse) + pre) * COARSE_U + (ph / 2) * HALF_U + tp * PB + fn;
      chk(pos == ep[g], {tag, " R5/R6/R7/R8/R10 final position"}, pos, ep[g]);
    end
    chk(map_bad == 0, alt ? {tag, " R4 alternate lanes"} : {tag, " R3 normal lanes"}, map_bad, 0);
    chk(order_bad == 0 && n_samples > 0, {tag, " R2 sample after setting"}, order_bad, 0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && err == 1'b0, "R1 reset done/err", int'({done, err}), 0);
    chk(apply_req == 1'b0 && smp_req == 1'b0, "R1 reset requests", int'({apply_req, smp_req}), 0);
  endtask

  task automatic t_normal_a;
    logic [CW-1:0] c0;
    logic [2*NG-1:0] p0;
    set_model(700, 720, 850, 800, 900, 940, 1000, 1010, 260);
    run_cal(1'b0);
    check_results(1'b0, "normal-A");
    c0 = res_coarse;
    p0 = res_pre;
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && res_coarse == c0 && res_pre == p0, "R12 results held",
        int'(res_pre), int'(p0));
    chk(apply_req == 1'b0 && smp_req == 1'b0, "R1 quiet while done",
        int'({apply_req, smp_req}), 0);
  endtask

  task automatic t_normal_b;
    set_model(400, 430, 500, 470, 610, 590, 455, 455, 260);
    run_cal(1'b0);
    check_results(1'b0, "normal-B");
  endtask

  task automatic t_alt;
    set_model(700, 1500, 1500, 760, 1500, 900, 820, 1500, 260);
    run_cal(1'b1);
    check_results(1'b1, "alt");
  endtask

  task automatic t_pre_range;
    set_model(700, 700, 800, 800, 900, 900, 1300, 1300, 260);
    run_cal(1'b0);
    chk(err == 1'b1 && err_code == 2'd3, "R9 pre-delay range error", int'(err_code), 3);
  endtask

  task automatic t_underflow;
    set_model(700, 700, 700, 700, 700, 700, 700, 700, 40);
    run_cal(1'b0);
    chk(err == 1'b1 && err_code == 2'd1, "R10 coarse underflow error", int'(err_code), 1);
  endtask

  task automatic t_watchdog;
    set_model(700, 700, 700, 700, 700, 700, 700, 700, 260);
    stuck_low[1] = 1'b1;
    run_cal(1'b0);
    chk(err == 1'b1 && err_code == 2'd2, "R11 watchdog error", int'(err_code), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      edge_e[i] = 700;
      stuck_low[i] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal_a();
    t_normal_b();
    t_alt();
    t_pre_range();
    t_underflow();
    t_watchdog();
    t_normal_a();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule